// File: doc/BRIEF.md
# Timebase Bit-Tap Interval Timer

The block turns a free-running 64-bit timebase into two periodic event streams, one for a fixed-interval timer and one for a watchdog. Each stream watches a single timebase bit chosen by its own period field. An event is raised whenever that bit moves from 0 to 1, so with a timebase that counts by one the events are spaced 2^(index+1) counts apart. The timebase itself comes from outside the block.

Software writes a control word to pick the tapped bits and the interrupt enables. It clears status bits by writing ones to them. A fixed-interval event sets a sticky status flag. A watchdog event moves a three-stage ladder forward: first an enable-next flag, then an interrupt flag, then a reset-status field. A resume pulse clears the whole watchdog ladder in one cycle. Each interrupt output is the matching status flag gated by its enable.

A build-time parameter picks how a bit index is formed. In extended mode it is 63 minus a 6-bit value built from a 2-bit period field and a 4-bit extension. In legacy mode the 2-bit field selects one entry from a 4-entry table of indices.

Top module: `tap_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sts_o` reads zero and both interrupt outputs are low.
- R2: In extended mode (EXT_MODE=1) the fixed-interval tap index is 63 − {ctl[16:13], ctl[25:24]} and the watchdog tap index is 63 − {ctl[20:17], ctl[31:30]}.
- R3: In legacy mode (EXT_MODE=0) the fixed-interval index is entry ctl[25:24] of FIT_TAB and the watchdog index is entry ctl[31:30] of WDT_TAB. Entry k sits at bits [6k+5:6k].
- R4: A timer's event happens at a clock edge where its tapped bit is sampled 1, the same bit was sampled 0 at the previous edge, and the index has not changed. Its effect shows after that edge. After reset the bit must first be sampled 0. When the timebase advances by one per cycle, events come 2^(index+1) cycles apart.
- R5: A fixed-interval event sets status bit 26.
- R6: A watchdog event does exactly one of the following, in this order of preference. It sets bit 31 if bit 31 is clear. Otherwise it sets bit 30 if bit 30 is clear. Otherwise, if bits [29:28] are zero, it loads them from ctl[29:28]. Otherwise it changes nothing.
- R7: `fit_irq_o` equals status bit 26 AND ctl[23`]`. `wdt_irq_o` equals status bit 30 AND ctl[27].
- R8: A status write with `sts_we_i` clears every status bit whose bit in `sts_wdata_i` is 1. An event in the same cycle wins over the clear. After a clear, the next event sets the bit again.
- R9: `resume_i` clears status bits [31:28] at the next edge. It wins over a watchdog event in the same cycle.
- R10: On the edge where a tap index changes, no event is produced, even if the old bit was 0 and the new bit is 1.
- R11: Status bits 27 and [25:0] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tb_i | input | 64 | Free-running timebase |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 32 | Control write data |
| sts_we_i | input | 1 | Status write-one-to-clear strobe |
| sts_wdata_i | input | 32 | Status clear mask |
| resume_i | input | 1 | Clears the watchdog ladder bits |
| sts_o | output | 32 | Status register value |
| fit_irq_o | output | 1 | Fixed-interval interrupt |
| wdt_irq_o | output | 1 | Watchdog interrupt |

## Verification
A stale edge register or a wrong tap index changes the spacing of status-bit sets. The bench sees this one cycle after the first misplaced timebase transition, because each event is observed while a clear is pulsed every cycle. A watchdog ladder that skips or repeats a stage shows up in `sts_o[31:28]` at the next watchdog event. A wrong mask or wrong priority between a clear, a resume and an event shows on the cycle right after the conflicting strobe. Both index modes are checked side by side against a model of the requirements on every cycle.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  localparam int TB_W   = 64;
  localparam int IDX_W  = $clog2(TB_W);
  localparam int TAB_N  = 4;

  localparam int CTL_WDT_PER = 30;
  localparam int CTL_WRC     = 28;
  localparam int CTL_WIE     = 27;
  localparam int CTL_FIT_PER = 24;
  localparam int CTL_FIE     = 23;
  localparam int CTL_WDT_EXT = 17;
  localparam int CTL_FIT_EXT = 13;

  localparam int STS_WDT_LSB = 28;
  localparam int STS_FIS     = 26;

  typedef logic [IDX_W-1:0] tap_idx_t;

  typedef struct packed {
    logic       enw;
    logic       wis;
    logic [1:0] wrs;
  } wdt_sts_t;
endpackage

// File: rtl/tap_sel.sv
module tap_sel
  import tap_timer_pkg::*;
#(
  parameter bit                         EXT_MODE = 1'b1,
  parameter logic [TAB_N*IDX_W-1:0]     TAB      = '0
) (
  input  logic [1:0] per_i,
  input  logic [3:0] ext_i,
  output tap_idx_t   idx_o
);
  generate
    if (EXT_MODE) begin : g_ext
      assign idx_o = tap_idx_t'(TB_W - 1) - {ext_i, per_i};
    end else begin : g_tab
      logic unused_ext;
      assign unused_ext = ^ext_i;
      assign idx_o = TAB[IDX_W*int'(per_i) +: IDX_W];
    end
  endgenerate
endmodule

// File: rtl/tap_edge.sv
module tap_edge
  import tap_timer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_i,
  input  tap_idx_t        idx_i,
  output logic            evt_o
);
  logic     tap_now, tap_q;
  tap_idx_t idx_q;

  assign tap_now = tb_i[idx_i];

  // tap_q resets high so a rise needs a sampled 0 first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q <= 1'b1;
      idx_q <= '1;
    end else begin
      tap_q <= tap_now;
      idx_q <= idx_i;
    end
  end

  assign evt_o = tap_now & ~tap_q & (idx_i == idx_q);
endmodule

// File: rtl/tap_wdt_step.sv
module tap_wdt_step
  import tap_timer_pkg::*;
(
  input  wdt_sts_t   cur_i,
  input  logic       evt_i,
  input  logic [1:0] wrc_i,
  output wdt_sts_t   nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (evt_i) begin
      if (!cur_i.enw)            nxt_o.enw = 1'b1;
      else if (!cur_i.wis)       nxt_o.wis = 1'b1;
      else if (cur_i.wrs == '0)  nxt_o.wrs = wrc_i;
    end
  end
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter bit                     EXT_MODE = 1'b1,
  parameter logic [TAB_N*IDX_W-1:0] FIT_TAB  = {6'd9, 6'd13, 6'd17, 6'd21},
  parameter logic [TAB_N*IDX_W-1:0] WDT_TAB  = {6'd21, 6'd25, 6'd29, 6'd33}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_i,
  input  logic            ctl_we_i,
  input  logic [31:0]     ctl_wdata_i,
  input  logic            sts_we_i,
  input  logic [31:0]     sts_wdata_i,
  input  logic            resume_i,
  output logic [31:0]     sts_o,
  output logic            fit_irq_o,
  output logic            wdt_irq_o
);
  localparam int N_CH = 2;

  logic [31:0] ctl_q;
  logic        fis_q;
  wdt_sts_t    wdt_q, wdt_clr, wdt_step;
  tap_idx_t    idx [N_CH];
  logic        evt [N_CH];
  logic        fit_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_wdata_i;
  end

  // channel 0: fixed interval, channel 1: watchdog
  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam logic [TAB_N*IDX_W-1:0] TAB = (c == 0) ? FIT_TAB : WDT_TAB;
      localparam int PER_LSB = (c == 0) ? CTL_FIT_PER : CTL_WDT_PER;
      localparam int EXT_LSB = (c == 0) ? CTL_FIT_EXT : CTL_WDT_EXT;

      tap_sel #(.EXT_MODE(EXT_MODE), .TAB(TAB)) u_sel (
        .per_i (ctl_q[PER_LSB +: 2]),
        .ext_i (ctl_q[EXT_LSB +: 4]),
        .idx_o (idx[c])
      );

      tap_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tb_i   (tb_i),
        .idx_i  (idx[c]),
        .evt_o  (evt[c])
      );
    end
  endgenerate

  assign fit_clr = sts_we_i & sts_wdata_i[STS_FIS];
  assign wdt_clr = wdt_q & ~(sts_we_i ? sts_wdata_i[STS_WDT_LSB +: 4] : 4'b0);

  tap_wdt_step u_wdt_step (
    .cur_i (wdt_clr),
    .evt_i (evt[1]),
    .wrc_i (ctl_q[CTL_WRC +: 2]),
    .nxt_o (wdt_step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fis_q <= 1'b0;
      wdt_q <= '0;
    end else begin
      fis_q <= evt[0] | (fis_q & ~fit_clr);
      wdt_q <= resume_i ? '0 : wdt_step;
    end
  end

  assign sts_o     = {wdt_q, 1'b0, fis_q, 26'b0};
  assign fit_irq_o = fis_q & ctl_q[CTL_FIE];
  assign wdt_irq_o = wdt_q.wis & ctl_q[CTL_WIE];

  logic unused_ctl, unused_sts;
  assign unused_ctl = ^{ctl_q[26], ctl_q[22:21], ctl_q[12:0]};
  assign unused_sts = ^{sts_wdata_i[27], sts_wdata_i[25:0]};

  // R5
  fit_evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt[0] |=> fis_q);

  // R8
  fit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && sts_wdata_i[STS_FIS] && !evt[0]) |=> !fis_q);

  // R9
  resume_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i |=> (sts_o[31:28] == 4'b0));

  // R6
  wdt_evt_enw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt[1] && !resume_i && !sts_we_i) |=> wdt_q.enw);

  // R10
  idx_change_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((idx[0] != $past(idx[0])) && !fis_q) |=> !fis_q);
endmodule

// File: tb/tap_timer_bench.sv
`timescale 1ns/1ps
module tap_timer_bench;
  localparam logic [23:0] LEG_FIT = {6'd7, 6'd5, 6'd3, 6'd2};
  localparam logic [23:0] LEG_WDT = {6'd8, 6'd6, 6'd4, 6'd1};
  localparam logic [31:0] STS_MASK = 32'hF400_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tb = '0;
  logic        ctl_we = 1'b0, sts_we = 1'b0, resume = 1'b0;
  logic [31:0] ctl_wd = '0, sts_wd = '0;
  logic [31:0] sts [2];
  logic        fit_irq [2], wdt_irq [2];

  int    total = 0, bad = 0;
  string tag = "R1";

  logic [31:0] m_ctl;
  logic [31:0] m_sts [2];
  logic        m_tapq [2][2];
  logic [5:0]  m_idxq [2][2];

  always #10 clk = ~clk;

  tap_timer u_tap_timer (
    .clk_i(clk), .rst_ni(rst_n), .tb_i(tb), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wd), .resume_i(resume),
    .sts_o(sts[0]), .fit_irq_o(fit_irq[0]), .wdt_irq_o(wdt_irq[0]));

  tap_timer #(.EXT_MODE(1'b0), .FIT_TAB(LEG_FIT), .WDT_TAB(LEG_WDT)) u_tap_legacy (
    .clk_i(clk), .rst_ni(rst_n), .tb_i(tb), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wd), .resume_i(resume),
    .sts_o(sts[1]), .fit_irq_o(fit_irq[1]), .wdt_irq_o(wdt_irq[1]));

  function automatic logic [5:0] idx_of(int inst, int ch, logic [31:0] c);
    logic [1:0] per = (ch != 0) ? c[31:30] : c[25:24];
    logic [3:0] ex  = (ch != 0) ? c[20:17] : c[16:13];
    if (inst == 0) return 6'd63 - {ex, per};
    if (ch == 0)   return LEG_FIT[6*int'(per) +: 6];
    return LEG_WDT[6*int'(per) +: 6];
  endfunction

  function automatic logic [31:0] sts_next(logic [31:0] s, logic fev, logic wev,
      logic [31:0] c, logic we, logic [31:0] wd, logic res);
    logic [31:0] n = s;
    if (we) n = n & ~wd;
    n = n & STS_MASK;
    if (fev) n[26] = 1'b1;
    if (wev) begin
      if (!n[31])                n[31] = 1'b1;
      else if (!n[30])           n[30] = 1'b1;
      else if (n[29:28] == 2'b0) n[29:28] = c[29:28];
    end
    if (res) n[31:28] = 4'b0;
    return n;
  endfunction

  function automatic logic [31:0] ctl_of(logic [1:0] fper, logic [3:0] fext,
      logic [1:0] wper, logic [3:0] wext, logic [1:0] wrc);
    logic [31:0] c = '0;
    c[25:24] = fper; c[16:13] = fext; c[31:30] = wper; c[20:17] = wext;
    c[29:28] = wrc;  c[23] = 1'b1;    c[27] = 1'b1;
    return c;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl = '0;
    for (int i = 0; i < 2; i++) begin
      m_sts[i] = '0;
      for (int c = 0; c < 2; c++) begin m_tapq[i][c] = 1'b1; m_idxq[i][c] = 6'h3f; end
    end
  endtask

  // one clock: update model from driven inputs, then compare at negedge
  task automatic tick();
    for (int i = 0; i < 2; i++) begin
      logic ev [2];
      for (int c = 0; c < 2; c++) begin
        logic [5:0] ix = idx_of(i, c, m_ctl);
        logic b = tb[ix];
        ev[c] = b && !m_tapq[i][c] && (ix == m_idxq[i][c]);
        m_tapq[i][c] = b;
        m_idxq[i][c] = ix;
      end
      m_sts[i] = sts_next(m_sts[i], ev[0], ev[1], m_ctl, sts_we, sts_wd, resume);
    end
    if (ctl_we) m_ctl = ctl_wd;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(sts[i], m_sts[i], "sts");
      chk({31'b0, fit_irq[i]}, {31'b0, m_sts[i][26] & m_ctl[23]}, "fit_irq");
      chk({31'b0, wdt_irq[i]}, {31'b0, m_sts[i][30] & m_ctl[27]}, "wdt_irq");
    end
    ctl_we = 1'b0; sts_we = 1'b0; resume = 1'b0;
  endtask

  task automatic write_ctl(logic [31:0] v);
    ctl_we = 1'b1; ctl_wd = v; tick();
  endtask

  // R4 R8 spacing: clear bit 26 every cycle, events show as single-cycle sets
  task automatic run_spacing(logic [31:0] c, int n, int ix0, int ix1);
    int last [2];
    int cnt [2];
    write_ctl(c);
    last[0] = -1; last[1] = -1; cnt[0] = 0; cnt[1] = 0;
    for (int k = 0; k < n; k++) begin
      tb = tb + 64'd1;
      sts_we = 1'b1; sts_wd = 32'h0400_0000;
      tick();
      for (int i = 0; i < 2; i++) begin
        if (sts[i][26]) begin
          cnt[i]++;
          if (last[i] >= 0) begin
            tag = (i == 0) ? "R4 R2 R8" : "R4 R3 R8";
            chk(k - last[i], 1 << ((i == 0 ? ix0 : ix1) + 1), "gap");
          end
          last[i] = k;
        end
      end
    end
    tag = "R4 R8";
    chk({31'b0, cnt[0] >= 2}, 32'd1, "ext event count");
    chk({31'b0, cnt[1] >= 2}, 32'd1, "legacy event count");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (2) @(negedge clk);
    tag = "R1";
    for (int i = 0; i < 2; i++) begin
      chk(sts[i], 32'h0, "reset sts");
      chk({30'b0, fit_irq[i], wdt_irq[i]}, 32'h0, "reset irqs");
    end
    rst_n = 1'b1;
    tick();

    // spacing across encodings
    run_spacing(ctl_of(2'd0, 4'hF, 2'd0, 4'hF, 2'd0), 160, 3, 2);
    run_spacing(ctl_of(2'd2, 4'hF, 2'd0, 4'hF, 2'd0), 200, 1, 5);
    run_spacing(ctl_of(2'd1, 4'hE, 2'd0, 4'hF, 2'd0), 400, 6, 3);

    // R10: index change onto a high bit with no event
    tag = "R10";
    sts_we = 1'b1; sts_wd = '1; tick();
    tb = 64'h0000_0000_0001_0002;
    write_ctl(ctl_of(2'd0, 4'hF, 2'd0, 4'hF, 2'd0));
    repeat (2) tick();
    write_ctl(ctl_of(2'd2, 4'hF, 2'd0, 4'hF, 2'd0));
    repeat (3) tick();
    chk({31'b0, sts[0][26]}, 32'd0, "no spurious event");

    // R6 R7 watchdog ladder, fixed interval parked on bit 63
    tag = "R6 R7";
    write_ctl(ctl_of(2'd0, 4'h0, 2'd0, 4'hF, 2'b10));
    tb = 64'h1000;
    sts_we = 1'b1; sts_wd = '1; tick();
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 16; k++) begin tb = tb + 64'd1; tick(); end
      case (s)
        0: chk({28'b0, sts[0][31:28]}, 32'h8, "ladder stage 1");
        1: chk({28'b0, sts[0][31:28]}, 32'hC, "ladder stage 2");
        default: chk({28'b0, sts[0][31:28]}, 32'hE, "ladder stage 3");
      endcase
      chk({31'b0, wdt_irq[0]}, {31'b0, s >= 1}, "wdt_irq");
    end

    // R9 resume
    tag = "R9";
    resume = 1'b1; tick();
    chk({28'b0, sts[0][31:28]}, 32'h0, "resume clears ladder");

    // R11 + random mix
    tag = "R2 R3 R5 R6 R7 R8 R9 R11";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 100 < 85) tb = tb + 64'(1 + $urandom % 3);
      else tb = {$urandom, $urandom};
      if ($urandom % 50 == 0) begin
        logic [31:0] c = $urandom;
        if ($urandom % 2 == 1) begin c[16:14] = 3'b111; c[20:18] = 3'b111; end
        ctl_we = 1'b1; ctl_wd = c;
      end
      if ($urandom % 20 == 0) begin sts_we = 1'b1; sts_wd = $urandom; end
      if ($urandom % 100 == 0) resume = 1'b1;
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule